// File: doc/BRIEF.md
# Telephone Ring Frequency Qualifier

This block decides whether the alternating signal on a telephone line is a real ring. An analog detector upstream sends it one single-cycle pulse for every threshold crossing of the ring waveform. A ring tone crosses the threshold twice per period, so a 20 Hz ring produces a crossing every 25 ms. The block measures the time between successive crossings against a programmable window. It reports whether the ring is valid, flags rings whose crossings arrive too fast or too slowly, and reports when the ring has stopped.

Time is measured in ticks of nominally 2 ms, made by a prescaler from the system clock. Each crossing loads a spacing timer with the start value `ras_i`, and each tick counts the timer down. When the next crossing arrives, the value left in the timer must not be above the margin `rmx_i`. That sets the shortest accepted spacing at (`ras_i` − `rmx_i`) ticks. If the timer runs out before the next crossing, the crossings are too far apart.

A separate quiet timer ends the ring once no crossing has occurred for a coded timeout. The timeout is `rto_i` steps of 64 ticks, which is 128 ms per step.

Top module: `ring_freq_qual`

## Requirements
- R1: While `rst` is high (synchronous), all three outputs are low from the next rising edge onwards.
- R2: Rising edges with `rst` low are counted from 0. A tick happens on every edge whose count modulo `TICK_DIV` equals `TICK_DIV`−1. A crossing loads the spacing timer with `ras_i`, and each later tick lowers it by one. The crossing's own edge does not decrement.
- R3: Let N be the number of ticks between two crossings. If N < `ras_i` − `rmx_i` (the timer is still above `rmx_i`), `ring_bad_o` is high for exactly the cycle after the second crossing's edge.
- R4: If the timer reaches zero on the `ras_i`-th tick after a crossing, `ring_bad_o` is high for the cycle after that tick. The timer then stops at zero, and the next crossing starts a new measurement without a verdict.
- R5: An interval with `ras_i` − `rmx_i` ≤ N ≤ `ras_i` − 1 is accepted and raises no `ring_bad_o`.
- R6: `ring_valid_o` goes high two cycles after the edge of the crossing that closes the second accepted interval in a row. A single accepted interval leaves it low.
- R7: `ring_valid_o` is low in the cycle after any `ring_bad_o` pulse, and the count of accepted intervals starts again from zero.
- R8: `ring_end_o` pulses for one cycle on the (`rto_i` × `STEP_TICKS`)-th tick after the most recent crossing. `STEP_TICKS` defaults to 64. Any crossing restarts this count.
- R9: An `rto_i` code of 0 gives the same timeout as code 1.
- R10: Each quiet period gives exactly one `ring_end_o` pulse, and `ring_valid_o` is low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xing_i | input | 1 | Single-cycle pulse per ring threshold crossing |
| ras_i | input | 6 | Spacing timer start value, in ticks |
| rmx_i | input | 4 | Largest remaining timer value still accepted |
| rto_i | input | 4 | Quiet timeout code, in steps of `STEP_TICKS` ticks |
| ring_valid_o | output | 1 | High while the ring is qualified |
| ring_bad_o | output | 1 | One-cycle pulse when a crossing interval is rejected |
| ring_end_o | output | 1 | One-cycle pulse when the quiet timeout expires |

## Verification
Crossing trains are driven with spacings exactly at both edges of the accept window and one tick outside each edge. This separates an off-by-one in the margin comparison from an off-by-one in the timer load or decrement. Two window settings are used, so a compare that ignores `rmx_i` or `ras_i` shows up.

Expiry of the spacing timer and of the quiet timeout is checked at the exact cycle, one cycle early and one cycle late. This is repeated for several `rto_i` codes, including zero. A train with a second crossing inside the quiet period shows whether a crossing restarts the quiet count.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

    localparam int RAS_W = 6;
    localparam int RMX_W = 4;
    localparam int RTO_W = 4;
    localparam int RTO_MAX_CODE = (1 << RTO_W) - 1;

    typedef enum logic [1:0] {
        GAP_NONE = 2'd0,
        GAP_GOOD = 2'd1,
        GAP_FAST = 2'd2,
        GAP_SLOW = 2'd3
    } gap_verdict_e;

    typedef struct packed {
        logic [RAS_W-1:0] ras;
        logic [RMX_W-1:0] rmx;
        logic [RTO_W-1:0] rto;
    } qual_cfg_t;

    function automatic logic is_reject(input gap_verdict_e v);
        return (v == GAP_FAST) || (v == GAP_SLOW);
    endfunction

    function automatic int unsigned quiet_ticks(input logic [RTO_W-1:0] code,
                                                input int unsigned step);
        int unsigned mult;
        mult = (code == '0) ? 1 : int'(code);
        return mult * step;
    endfunction

endpackage

// File: rtl/rfq_tick_gen.sv
module rfq_tick_gen #(
    parameter int TICK_DIV = 100000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick_o = !rst && (cnt_q == LAST);

endmodule

// File: rtl/rfq_spacing_timer.sv
module rfq_spacing_timer
    import rfq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 xing_i,
    input  logic [RAS_W-1:0]     ras_i,
    input  logic [RMX_W-1:0]     rmx_i,
    output gap_verdict_e         verdict_o
);
    logic [RAS_W-1:0] tmr_q;
    logic             armed_q;
    gap_verdict_e     verdict_q;
    logic [RAS_W-1:0] margin_w;

    assign margin_w = {{(RAS_W-RMX_W){1'b0}}, rmx_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q     <= '0;
            armed_q   <= 1'b0;
            verdict_q <= GAP_NONE;
        end else begin
            verdict_q <= GAP_NONE;
            if (xing_i) begin
                if (armed_q) begin
                    verdict_q <= (tmr_q > margin_w) ? GAP_FAST : GAP_GOOD;
                end
                tmr_q   <= ras_i;
                armed_q <= 1'b1;
            end else if (tick_i && armed_q) begin
                if (tmr_q <= RAS_W'(1)) begin
                    tmr_q     <= '0;
                    armed_q   <= 1'b0;
                    verdict_q <= GAP_SLOW;
                end else begin
                    tmr_q <= tmr_q - RAS_W'(1);
                end
            end
        end
    end

    assign verdict_o = verdict_q;

endmodule

// File: rtl/rfq_quiet_timer.sv
module rfq_quiet_timer
    import rfq_pkg::*;
#(
    parameter int STEP_TICKS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             xing_i,
    input  logic [RTO_W-1:0] rto_i,
    output logic             end_o
);
    localparam int QMAX = RTO_MAX_CODE * STEP_TICKS;
    localparam int QW   = $clog2(QMAX + 1);

    logic [QW-1:0] cnt_q;
    logic [QW-1:0] limit_w;
    logic          active_q;
    logic          end_q;

    assign limit_w = QW'(quiet_ticks(rto_i, STEP_TICKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            end_q    <= 1'b0;
        end else begin
            end_q <= 1'b0;
            if (xing_i) begin
                cnt_q    <= '0;
                active_q <= 1'b1;
            end else if (tick_i && active_q) begin
                if (cnt_q + QW'(1) >= limit_w) begin
                    cnt_q    <= '0;
                    active_q <= 1'b0;
                    end_q    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + QW'(1);
                end
            end
        end
    end

    assign end_o = end_q;

endmodule

// File: rtl/rfq_valid_tracker.sv
module rfq_valid_tracker
    import rfq_pkg::*;
#(
    parameter int NEED_GOOD = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  gap_verdict_e verdict_i,
    input  logic         end_i,
    output logic         valid_o
);
    localparam int GW = $clog2(NEED_GOOD + 1);
    localparam logic [GW-1:0] FULL = GW'(NEED_GOOD);

    logic [GW-1:0] good_q;
    logic [GW-1:0] good_nxt;
    logic          valid_q;

    always_comb begin
        good_nxt = good_q;
        if (is_reject(verdict_i) || end_i) begin
            good_nxt = '0;
        end else if (verdict_i == GAP_GOOD && good_q != FULL) begin
            good_nxt = good_q + GW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            good_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            good_q  <= good_nxt;
            valid_q <= (good_nxt == FULL);
        end
    end

    assign valid_o = valid_q;

endmodule

// File: rtl/ring_freq_qual.sv
module ring_freq_qual
    import rfq_pkg::*;
#(
    parameter int TICK_DIV   = 100000,
    parameter int STEP_TICKS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xing_i,
    input  logic [5:0] ras_i,
    input  logic [3:0] rmx_i,
    input  logic [3:0] rto_i,
    output logic       ring_valid_o,
    output logic       ring_bad_o,
    output logic       ring_end_o
);
    qual_cfg_t    cfg_w;
    logic         tick_w;
    gap_verdict_e verdict_q;
    logic         end_w;

    assign cfg_w = '{ras: ras_i, rmx: rmx_i, rto: rto_i};

    rfq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick_w)
    );

    rfq_spacing_timer u_space (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_w),
        .xing_i    (xing_i),
        .ras_i     (cfg_w.ras),
        .rmx_i     (cfg_w.rmx),
        .verdict_o (verdict_q)
    );

    rfq_quiet_timer #(.STEP_TICKS(STEP_TICKS)) u_quiet (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_w),
        .xing_i (xing_i),
        .rto_i  (cfg_w.rto),
        .end_o  (end_w)
    );

    rfq_valid_tracker #(.NEED_GOOD(2)) u_valid (
        .clk       (clk),
        .rst       (rst),
        .verdict_i (verdict_q),
        .end_i     (end_w),
        .valid_o   (ring_valid_o)
    );

    assign ring_bad_o = is_reject(verdict_q);
    assign ring_end_o = end_w;

endmodule

// File: rtl/rfq_checker.sv
module rfq_checker
    import rfq_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         xing_i,
    input logic         tick_i,
    input gap_verdict_e verdict_i,
    input logic         ring_valid_o,
    input logic         ring_bad_o,
    input logic         ring_end_o
);
    // R3 / R4: a reject needs a crossing or a tick on the edge before it
    p_bad_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
        ring_bad_o |-> ($past(xing_i) || $past(tick_i)));

    // R7: a reject drops validity on the following cycle
    p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
        ring_bad_o |=> !ring_valid_o);

    // R6: validity only rises right after an accepted interval
    p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ring_valid_o) |-> $past(verdict_i == GAP_GOOD));

    // R10: the end pulse lasts one cycle
    p_end_single_r10: assert property (@(posedge clk) disable iff (rst)
        ring_end_o |=> !ring_end_o);

    // R10: after the end pulse the ring is not valid
    p_end_clears_r10: assert property (@(posedge clk) disable iff (rst)
        ring_end_o |=> !ring_valid_o);

    // R8: the end pulse follows a tick and never a crossing
    p_end_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        ring_end_o |-> ($past(tick_i) && !$past(xing_i)));

endmodule

bind ring_freq_qual rfq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .xing_i       (xing_i),
    .tick_i       (tick_w),
    .verdict_i    (verdict_q),
    .ring_valid_o (ring_valid_o),
    .ring_bad_o   (ring_bad_o),
    .ring_end_o   (ring_end_o)
);

// File: tb/tb_ring_freq_qual.sv
module tb_ring_freq_qual;
    localparam int DIV  = 4;
    localparam int STEP = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xing = 1'b0;
    logic [5:0] ras = 6'd20;
    logic [3:0] rmx = 4'd5;
    logic [3:0] rto = 4'd1;
    logic       valid, bad, rend;

    int n_chk = 0;
    int n_fail = 0;
    int ph = 0;
    int bad_cnt = 0;
    int end_cnt = 0;
    bit done = 1'b0;

    ring_freq_qual #(.TICK_DIV(DIV), .STEP_TICKS(STEP)) dut (
        .clk          (clk),
        .rst          (rst),
        .xing_i       (xing),
        .ras_i        (ras),
        .rmx_i        (rmx),
        .rto_i        (rto),
        .ring_valid_o (valid),
        .ring_bad_o   (bad),
        .ring_end_o   (rend)
    );

    always #10 clk = ~clk;

    // tick phase model (R2) and pulse counters
    always @(posedge clk) begin
        if (rst) ph <= 0;
        else     ph <= (ph + 1) % DIV;
        if (!rst && bad)  bad_cnt <= bad_cnt + 1;
        if (!rst && rend) end_cnt <= end_cnt + 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // crossing on an edge where the prescaler count is 1 (never a tick edge)
    task automatic pulse_xing();
        while (ph != 1) @(negedge clk);
        xing = 1'b1;
        @(negedge clk);
        xing = 1'b0;
    endtask

    // from d=0 after a crossing, wait until the edge n ticks later is next
    task automatic gap(input int n);
        repeat (DIV * n - 1) @(negedge clk);
    endtask

    // watch for the end pulse, starting at offset d0 from the last crossing
    task automatic watch_end(input string req, input int d0, input int limit);
        int de;
        int e0;
        de = DIV * limit - 2;
        e0 = end_cnt;
        for (int d = d0; d <= de + 1; d++) begin
            if (d == de - 1) check(req, "end one cycle early", int'(rend), 0);
            if (d == de)     check(req, "end at timeout", int'(rend), 1);
            if (d == de + 1) begin
                check(req, "end one cycle late", int'(rend), 0);
                check("R10", "valid after end", int'(valid), 0);
            end
            @(negedge clk);
        end
        repeat (DIV * 8) @(negedge clk);
        check("R10", "end pulses per quiet period", end_cnt - e0, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", "valid in reset", int'(valid), 0);
        check("R1", "bad in reset", int'(bad), 0);
        check("R1", "end in reset", int'(rend), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_train();
        int b0;
        ras = 6'd20; rmx = 4'd5; rto = 4'd1;
        b0 = bad_cnt;
        pulse_xing(); gap(17);
        pulse_xing(); gap(17);
        check("R6", "valid after one interval", int'(valid), 0);
        pulse_xing();
        repeat (2) @(negedge clk);
        check("R6", "valid after two intervals", int'(valid), 1);
        check("R5", "no reject in train", bad_cnt - b0, 0);
        gap(17);
        pulse_xing();
    endtask

    task automatic t_fast();
        int b0;
        b0 = bad_cnt;
        gap(14);
        pulse_xing();
        check("R3", "reject on fast gap", int'(bad), 1);
        @(negedge clk);
        check("R3", "reject is one cycle", int'(bad), 0);
        check("R7", "valid after reject", int'(valid), 0);
        @(negedge clk);
        check("R3", "fast reject count", bad_cnt - b0, 1);
        repeat (DIV - 2) @(negedge clk);
    endtask

    task automatic t_window();
        int b0;
        b0 = bad_cnt;
        // last crossing was at d=0 DIV cycles ago; 15 ticks total spacing
        gap(14);
        pulse_xing();
        check("R5", "lowest accepted spacing", int'(bad), 0);
        gap(19);
        pulse_xing();
        check("R5", "highest accepted spacing", int'(bad), 0);
        repeat (2) @(negedge clk);
        check("R6", "valid after window edges", int'(valid), 1);
        check("R5", "no reject at window edges", bad_cnt - b0, 0);
    endtask

    task automatic t_slow_then_end();
        int de;
        de = DIV * 20 - 2;
        // two negedges already passed since the last crossing
        for (int d = 2; d <= de + 1; d++) begin
            if (d == de - 1) check("R4", "no reject before expiry", int'(bad), 0);
            if (d == de)     check("R4", "reject at expiry", int'(bad), 1);
            if (d == de + 1) begin
                check("R4", "expiry reject one cycle", int'(bad), 0);
                check("R7", "valid after slow reject", int'(valid), 0);
            end
            @(negedge clk);
        end
        watch_end("R8", de + 2, STEP);
    endtask

    task automatic t_restart();
        rto = 4'd1;
        pulse_xing(); gap(40);
        pulse_xing();
        watch_end("R8", 0, STEP);
    endtask

    task automatic t_rto_codes();
        rto = 4'd0;
        pulse_xing();
        watch_end("R9", 0, STEP);
        rto = 4'd2;
        pulse_xing();
        watch_end("R8", 0, 2 * STEP);
    endtask

    task automatic t_alt_window();
        ras = 6'd10; rmx = 4'd3; rto = 4'd1;
        pulse_xing(); gap(6);
        pulse_xing();
        check("R3", "fast with second window", int'(bad), 1);
        gap(7);
        pulse_xing();
        check("R5", "lowest spacing second window", int'(bad), 0);
        gap(9);
        pulse_xing();
        check("R5", "highest spacing second window", int'(bad), 0);
        repeat (2) @(negedge clk);
        check("R6", "valid second window", int'(valid), 1);
        gap(10);
        pulse_xing();
        check("R4", "crossing after expiry gives no verdict", int'(bad), 0);
        repeat (2) @(negedge clk);
        check("R7", "valid after expiry", int'(valid), 0);
    endtask

    initial begin
        t_reset();
        t_train();
        t_fast();
        t_window();
        t_slow_then_end();
        t_restart();
        t_rto_codes();
        t_alt_window();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule